// File: doc/BRIEF.md
# Endpoint Control Register with CPU/Engine Arbitration

This block holds the 8-bit control and status register of a USB device's default control endpoint. Two agents touch it. A CPU reaches it through simple I/O read and write strobes. The USB serial engine reports three kinds of transaction events:
- the start of the data phase of a setup transaction;
- the start of the handshake it returns;
- the end of a completed transaction, which carries new values for the lower seven bits.

The block settles every conflict between these agents in a fixed order.

Bit 7 is the setup flag. It is forced high for the whole setup data phase and stays protected against clearing by the CPU until the CPU reads the register again. The lower seven bits are locked against CPU writes once the engine has loaded them, and a CPU read releases the lock. Bits [3:0] give the endpoint's response mode and are also brought out on their own.

While the setup flag is high, the block blocks CPU writes into two 8-byte windows of the endpoint buffer address space. This keeps a buffer fill that firmware started earlier from overwriting incoming setup data.

Top module: `ep_ctl_reg_arbiter`

## Requirements
- R1: One cycle after `sieSetupDataStart` is pulsed, `regValue[7]` reads 1, and it stays 1 until the cycle after `sieAckStart`.
- R2: After `sieSetupDataStart`, a CPU write cannot clear bit 7. This holds during the forced interval and afterwards. The protection ends only in the cycle after the first CPU read strobe that is given after the forced interval has ended. A read given during the forced interval does not end it.
- R3: With the lock clear, a CPU write sets `regValue[6:0]` to `cpuWrData[6:0]` in the next cycle. With the lock set, a CPU write leaves `regValue[6:0]` unchanged.
- R4: `sieUpdStb` loads `sieUpdData` into `regValue[6:0]` in the next cycle and sets the lock. It leaves bit 7 unchanged.
- R5: A CPU read strobe clears the lock from the next cycle on, unless `sieUpdStb` is given in the same cycle.
- R6: While `regValue[7]` is 1, `bufWrEn` is 0 for every `bufWrAddr` in 0xE0–0xE7 or 0xF8–0xFF. In all other cases `bufWrEn` equals `bufWrReq`, with no added delay.
- R7: `epMode` always equals `regValue[3:0]`.
- R8: When a CPU write and `sieUpdStb` fall in the same cycle, the engine's value is loaded into bits [6:0] and the lock is set.
- R9: After reset, `regValue` is 0x00, the lock is clear, bit 7 is writable, and `bufWrEn` follows `bufWrReq` at every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuRdStb | input | 1 | CPU read of the register, one cycle |
| cpuWrStb | input | 1 | CPU write of the register, one cycle |
| cpuWrData | input | 8 | CPU write data |
| sieSetupDataStart | input | 1 | Engine: data phase of a setup transaction begins |
| sieAckStart | input | 1 | Engine: handshake it returns begins |
| sieUpdStb | input | 1 | Engine: transaction complete, load new field values |
| sieUpdData | input | 7 | Engine's new value for bits [6:0] |
| bufWrReq | input | 1 | CPU write request to the endpoint buffer |
| bufWrAddr | input | 8 | CPU buffer write address |
| regValue | output | 8 | Current register contents |
| epMode | output | 4 | Endpoint response mode, bits [3:0] |
| bufWrEn | output | 1 | Gated buffer write enable |

## Verification
The assertions assume that the engine never gives `sieSetupDataStart` and `sieAckStart` in the same cycle. They also assume that every handshake start follows a setup data start. Both assumptions match the order of a real transaction. The stimulus keeps within them by driving the engine events only as ordered sequences of single-cycle pulses, while CPU reads, writes and engine updates are freely mixed around and inside those sequences, including same-cycle collisions. The bench compares the register after every cycle against a model built from the requirements. It also sweeps all 256 write values and all 256 buffer addresses with the flag low and with the flag high.

// File: rtl/ep_ctl_pkg.sv
package ep_ctl_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic forceFlag;   // setup data phase began: set bit 7
    logic writeFlag;   // CPU write may update bit 7
    logic loadSie;     // engine update of the low bits
    logic writeLow;    // CPU write may update the low bits
  } regStrobes_t;
endpackage

// File: rtl/ep_ctl_control.sv
module ep_ctl_control
  import ep_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuRdStb,
  input  logic        cpuWrStb,
  input  logic        sieSetupDataStart,
  input  logic        sieAckStart,
  input  logic        sieUpdStb,
  input  logic        flagIn,
  output regStrobes_t strobes,
  output logic        lowLocked
);
  logic setupForced;
  logic clearBlock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupForced <= 1'b0;
      clearBlock  <= 1'b0;
      lowLocked   <= 1'b0;
    end else begin
      if (sieSetupDataStart)   setupForced <= 1'b1;
      else if (sieAckStart)    setupForced <= 1'b0;

      if (sieSetupDataStart)                clearBlock <= 1'b1;
      else if (cpuRdStb && !setupForced)    clearBlock <= 1'b0;

      if (sieUpdStb)           lowLocked <= 1'b1;
      else if (cpuRdStb)       lowLocked <= 1'b0;
    end
  end

  always_comb begin
    strobes.forceFlag = sieSetupDataStart;
    strobes.writeFlag = cpuWrStb && !clearBlock;
    strobes.loadSie   = sieUpdStb;
    strobes.writeLow  = cpuWrStb && !lowLocked && !sieUpdStb;
  end

  // R1
  forced_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupForced |-> flagIn);

  // R2
  block_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    clearBlock && flagIn |=> flagIn);

  // R2
  forced_read_no_unblock_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupForced && !sieAckStart |=> clearBlock);

  // R8
  sie_wins_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    sieUpdStb |=> lowLocked);
endmodule

// File: rtl/ep_ctl_datapath.sv
module ep_ctl_datapath
  import ep_ctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                WIN_LOG2   = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE_A = 8'hE0,
  parameter logic [ADDR_W-1:0] WIN_BASE_B = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobes_t       strobes,
  input  logic [7:0]        cpuWrData,
  input  logic [6:0]        sieUpdData,
  input  logic              bufWrReq,
  input  logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        regValue,
  output logic              bufWrEn
);
  localparam int NUM_WIN = 2;
  localparam int TAG_W   = ADDR_W - WIN_LOG2;
  localparam logic [ADDR_W-1:0] WIN_BASES [NUM_WIN] = '{WIN_BASE_A, WIN_BASE_B};

  logic       flagQ;
  logic [6:0] lowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
      lowQ  <= '0;
    end else begin
      if (strobes.forceFlag)      flagQ <= 1'b1;
      else if (strobes.writeFlag) flagQ <= cpuWrData[7];

      if (strobes.loadSie)        lowQ <= sieUpdData;
      else if (strobes.writeLow)  lowQ <= cpuWrData[6:0];
    end
  end

  logic [NUM_WIN-1:0] winHit;
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign winHit[w] = (bufWrAddr[ADDR_W-1:WIN_LOG2] == WIN_BASES[w][ADDR_W-1:WIN_LOG2]);
  end

  logic [TAG_W-1:0] unusedTag;
  assign unusedTag = '0;

  assign bufWrEn  = bufWrReq && !(flagQ && (|winHit));
  assign regValue = {flagQ, lowQ};

  // R4
  sie_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadSie |=> (lowQ == $past(sieUpdData)) && (flagQ == $past(flagQ) || $past(strobes.forceFlag) || $past(strobes.writeFlag)));

  // R6
  no_write_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bufWrReq |-> !bufWrEn);
endmodule

// File: rtl/ep_ctl_reg_arbiter.sv
module ep_ctl_reg_arbiter
  import ep_ctl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                WIN_LOG2   = 3,
  parameter logic [ADDR_W-1:0] WIN_BASE_A = 8'hE0,
  parameter logic [ADDR_W-1:0] WIN_BASE_B = 8'hF8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRdStb,
  input  logic              cpuWrStb,
  input  logic [7:0]        cpuWrData,
  input  logic              sieSetupDataStart,
  input  logic              sieAckStart,
  input  logic              sieUpdStb,
  input  logic [6:0]        sieUpdData,
  input  logic              bufWrReq,
  input  logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        regValue,
  output logic [3:0]        epMode,
  output logic              bufWrEn
);
  regStrobes_t strobes;
  logic        lowLocked;

  ep_ctl_control i_control (
    .clk(clk), .rstN(rstN), .cpuRdStb(cpuRdStb), .cpuWrStb(cpuWrStb),
    .sieSetupDataStart(sieSetupDataStart), .sieAckStart(sieAckStart),
    .sieUpdStb(sieUpdStb), .flagIn(regValue[7]),
    .strobes(strobes), .lowLocked(lowLocked)
  );

  ep_ctl_datapath #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2),
    .WIN_BASE_A(WIN_BASE_A), .WIN_BASE_B(WIN_BASE_B)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cpuWrData(cpuWrData),
    .sieUpdData(sieUpdData), .bufWrReq(bufWrReq), .bufWrAddr(bufWrAddr),
    .regValue(regValue), .bufWrEn(bufWrEn)
  );

  assign epMode = regValue[3:0];

  // R3
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowLocked && !sieUpdStb |=> $stable(regValue[6:0]));

  // R5
  read_unlocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdStb && !sieUpdStb |=> !lowLocked);

  // R6
  window_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    regValue[7] && (bufWrAddr[ADDR_W-1:WIN_LOG2] == WIN_BASE_A[ADDR_W-1:WIN_LOG2]
                    || bufWrAddr[ADDR_W-1:WIN_LOG2] == WIN_BASE_B[ADDR_W-1:WIN_LOG2]) |-> !bufWrEn);

  // R1
  setup_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    sieSetupDataStart |=> regValue[7]);
endmodule

// File: tb/test_ep_ctl_reg_arbiter.sv
module test_ep_ctl_reg_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuRdStb = 0, cpuWrStb = 0, sieSetupDataStart = 0, sieAckStart = 0, sieUpdStb = 0, bufWrReq = 0;
  logic [7:0] cpuWrData = '0, bufWrAddr = '0;
  logic [6:0] sieUpdData = '0;
  logic [7:0] regValue;
  logic [3:0] epMode;
  logic bufWrEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model state
  logic mFlag = 0, mLock = 0, mForced = 0, mBlock = 0;
  logic [6:0] mLow = '0;

  always #10 clk = ~clk;

  ep_ctl_reg_arbiter i_ep_ctl_reg_arbiter (
    .clk(clk), .rstN(rstN), .cpuRdStb(cpuRdStb), .cpuWrStb(cpuWrStb), .cpuWrData(cpuWrData),
    .sieSetupDataStart(sieSetupDataStart), .sieAckStart(sieAckStart), .sieUpdStb(sieUpdStb),
    .sieUpdData(sieUpdData), .bufWrReq(bufWrReq), .bufWrAddr(bufWrAddr),
    .regValue(regValue), .epMode(epMode), .bufWrEn(bufWrEn)
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // one clock with the given strobes; model follows the requirements
  task automatic cyc(input logic rd, input logic wr, input logic [7:0] wd,
                     input logic ss, input logic ack, input logic upd,
                     input logic [6:0] ud, input string tag);
    logic nFlag, nLock, nForced, nBlock;
    logic [6:0] nLow;
    cpuRdStb = rd; cpuWrStb = wr; cpuWrData = wd;
    sieSetupDataStart = ss; sieAckStart = ack; sieUpdStb = upd; sieUpdData = ud;
    @(posedge clk); #1;
    cpuRdStb = 0; cpuWrStb = 0; sieSetupDataStart = 0; sieAckStart = 0; sieUpdStb = 0;
    nFlag   = ss ? 1'b1 : (wr && !mBlock) ? wd[7] : mFlag;          // R1 R2
    nLow    = upd ? ud : (wr && !mLock) ? wd[6:0] : mLow;           // R3 R4 R8
    nLock   = upd ? 1'b1 : rd ? 1'b0 : mLock;                       // R5
    nForced = ss ? 1'b1 : ack ? 1'b0 : mForced;
    nBlock  = ss ? 1'b1 : (rd && !mForced) ? 1'b0 : mBlock;
    mFlag = nFlag; mLow = nLow; mLock = nLock; mForced = nForced; mBlock = nBlock;
    chk(regValue, {mFlag, mLow}, tag);
    chk({4'h0, epMode}, {4'h0, mLow[3:0]}, "R7 mode bits");
  endtask

  task automatic sweepGate(input string tag);
    bufWrReq = 1;
    for (int a = 0; a < 256; a++) begin
      logic inWin;
      bufWrAddr = a[7:0];
      #1;
      inWin = (a >= 8'hE0 && a <= 8'hE7) || (a >= 8'hF8);
      chk({7'd0, bufWrEn}, {7'd0, !(mFlag && inWin)}, tag);
    end
    bufWrReq = 0; #1;
    chk({7'd0, bufWrEn}, 8'h00, tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(regValue, 8'h00, "R9 reset value");
    rstN = 1;
    @(posedge clk); #1;
    chk(regValue, 8'h00, "R9 value after release");
    sweepGate("R9 gate open after reset");

    // R3: unlocked writes of every value, bit 7 writable after reset (R9)
    for (int v = 0; v < 256; v++) cyc(0, 1, v[7:0], 0, 0, 0, '0, "R3 unlocked write");
    cyc(0, 1, 8'h80, 0, 0, 0, '0, "R6 set flag by write");
    sweepGate("R6 gate with flag high");
    cyc(0, 1, 8'h05, 0, 0, 0, '0, "R6 clear flag by write");
    sweepGate("R6 gate with flag low");

    // R4: engine load, then R3 locked writes ignored
    cyc(0, 0, '0, 0, 0, 1, 7'h55, "R4 engine load");
    for (int v = 0; v < 256; v++) cyc(0, 1, v[7:0], 0, 0, 0, '0, "R3 locked write ignored");
    cyc(1, 0, '0, 0, 0, 0, '0, "R5 read");
    cyc(0, 1, 8'h2A, 0, 0, 0, '0, "R5 write after unlock");

    // R8: collision, engine wins and locks
    cyc(0, 1, 8'h7F, 0, 0, 1, 7'h11, "R8 write and engine same cycle");
    cyc(0, 1, 8'h33, 0, 0, 0, '0, "R8 lock set by collision");
    cyc(1, 0, '0, 0, 0, 1, 7'h22, "R5 read and engine same cycle");
    cyc(0, 1, 8'h44, 0, 0, 0, '0, "R5 lock kept when engine coincides");
    cyc(1, 0, '0, 0, 0, 0, '0, "R5 read unlock");

    // R1 R2: setup sequence
    cyc(0, 0, '0, 1, 0, 0, '0, "R1 setup data start");
    sweepGate("R6 gate during setup");
    cyc(0, 1, 8'h00, 0, 0, 0, '0, "R2 clear attempt while forced");
    cyc(1, 0, '0, 0, 0, 0, '0, "R2 read while forced");
    cyc(0, 1, 8'h03, 0, 0, 0, '0, "R2 write while forced");
    cyc(0, 0, '0, 0, 1, 1, 7'h08, "R1 handshake start and engine update");
    cyc(0, 1, 8'h00, 0, 0, 0, '0, "R2 clear attempt after forced, before read");
    cyc(1, 0, '0, 0, 0, 0, '0, "R2 first read after forced");
    cyc(0, 1, 8'h06, 0, 0, 0, '0, "R2 clear after read");
    chk({7'd0, regValue[7]}, 8'h00, "R2 flag cleared after read");
    sweepGate("R6 gate after setup cleared");

    // mixed pattern sweep
    for (int i = 0; i < 64; i++) begin
      cyc(i[0], i[1], {i[5:0], i[1:0]}, i[5:0] == 6'd7, i[5:0] == 6'd20, i[2] && i[3], i[6:0] ^ 7'h5A, "R3 R4 R5 R8 mixed");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule